// File: doc/BRIEF.md
# I2C Message-List Transaction Sequencer

This block sits between a transfer requester and the command queue of an I2C bus master. The requester hands over a list of messages. Each message descriptor carries a target address, a direction and a byte count, and a flag marks the last message of the list. The sequencer expands every message into per-byte command words for the master. It feeds write bytes from a separate byte stream. For reads it issues one read command at a time and returns each received byte.

Bus conditions are decided per list. The first message of a list sets the current address and direction pair. A later message that changes either one gets a repeated START on its first byte. Only the last byte of the last message asks for a STOP. The master reports failures as abort causes, and the sequencer also watches for stalls that last too long. Either kind of failure ends the list early. When the list completes or fails, a single-cycle done pulse reports how many messages finished cleanly and a status code whose bits name the cause.

Top module: `i2c_msg_seq`

## Requirements
- R1: Each accepted write byte yields exactly one command word of layout {address, restart at bit 10, stop at bit 9, read at bit 8, data at bits 7:0}. A command word appears on `cmd_valid` one cycle after a cycle in which `cmd_full` was low, and never otherwise.
- R2: The first message of a list never sets restart. A later message whose address or direction differs from the last accepted one sets restart on its first command only.
- R3: Stop is set only on the final command of the final message of a list, and no command follows it before the done pulse.
- R4: A descriptor with length 0 issues no command and fails the list with status 0x10.
- R5: A read message issues one read command (data 0) per byte. It waits for `rx_valid`, pops it with `rx_pop`, and presents the byte on `rd_valid`/`rd_data` one cycle later before issuing the next read command.
- R6: After a failing message, the remaining descriptors up to the one flagged last are accepted and dropped without any command. Done then reports the number of messages that completed before the failure.
- R7: The abort cause is mapped to the status as follows: `abort_src` bit 1 (data NACK) gives 0x02, else bit 0 (address NACK) gives 0x01, else bit 2 (hardware timeout) gives 0x04, else 0x10. For writes, `abort` is sampled after all bytes are queued. For reads, it is sampled while waiting for data.
- R8: A state that waits on the master fails the list with status 0x08 once more than `tmo_limit` consecutive cycles pass without progress. Every accepted byte, issued command or popped byte restarts the count.
- R9: Completion raises `done` for exactly one cycle with the message count and status; a clean list reports status 0.
- R10: After reset, `desc_ready` is 1 and `cmd_valid`, `rd_valid` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor accepted this cycle when valid |
| desc_addr | input | ADDR_W | Target address of the message |
| desc_rd | input | 1 | 1 = read message, 0 = write message |
| desc_len | input | LEN_W | Byte count of the message |
| desc_last | input | 1 | Marks the final message of the list |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte taken this cycle when valid |
| wr_data | input | 8 | Write byte |
| cmd_valid | output | 1 | Command word valid (one push) |
| cmd_word | output | ADDR_W+11 | Command word for the master queue |
| cmd_full | input | 1 | Master command queue full |
| tx_empty | input | 1 | Master has drained its command queue |
| rx_valid | input | 1 | Master receive queue not empty |
| rx_data | input | 8 | Head of the master receive queue |
| rx_pop | output | 1 | Pop the receive queue head |
| abort | input | 1 | Master reports an aborted transfer |
| abort_src | input | 3 | Abort cause: bit0 address NACK, bit1 data NACK, bit2 hardware timeout |
| tmo_limit | input | TMO_W | Allowed stall cycles before a wait timeout |
| rd_valid | output | 1 | Returned read byte valid |
| rd_data | output | 8 | Returned read byte |
| done | output | 1 | One-cycle list completion pulse |
| done_count | output | CNT_W | Messages completed cleanly |
| done_status | output | 5 | Status code of the list |

## Verification
The bench builds the block with ADDR_W=7, LEN_W=4, CNT_W=4 and TMO_W=8, and drives `tmo_limit` at 20. The narrow timer lets a withheld write byte or a silent receiver reach the wait timeout within a few dozen cycles. A 15-cycle `cmd_full` stall stays under the limit and shows that the count restarts on progress. The short length field keeps every message small, so lists that mix writes and reads can exercise the restart and stop placement and the drain after a mid-list failure quickly.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

  localparam int STAT_W = 5;

  localparam logic [STAT_W-1:0] ST_OK        = 5'h00;
  localparam logic [STAT_W-1:0] ST_ADDR_NACK = 5'h01;
  localparam logic [STAT_W-1:0] ST_DATA_NACK = 5'h02;
  localparam logic [STAT_W-1:0] ST_HW_TMO    = 5'h04;
  localparam logic [STAT_W-1:0] ST_WAIT_TMO  = 5'h08;
  localparam logic [STAT_W-1:0] ST_ABORT     = 5'h10;

  typedef enum logic [2:0] {
    S_GET, S_WR, S_WR_WAIT, S_RD_ISS, S_RD_WAIT, S_DRAIN, S_DONE
  } seq_state_e;

  // data NACK outranks address NACK, which outranks hardware timeout
  function automatic logic [STAT_W-1:0] abort_code(input logic [2:0] src);
    if (src[1])      return ST_DATA_NACK;
    else if (src[0]) return ST_ADDR_NACK;
    else if (src[2]) return ST_HW_TMO;
    else             return ST_ABORT;
  endfunction

endpackage

// File: rtl/seq_stall_timer.sv
module seq_stall_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             progress,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);
  logic [TMO_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run || progress) cnt <= '0;
    else if (cnt < limit)        cnt <= cnt + 1'b1;
  end

  assign expired = run && !progress && (cnt >= limit);
endmodule

// File: rtl/seq_pair_track.sv
module seq_pair_track #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              list_start,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  output logic              restart
);
  logic [ADDR_W-1:0] cur_addr;
  logic              cur_rd;

  assign restart = !list_start && ((addr != cur_addr) || (rd != cur_rd));

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr <= '0;
      cur_rd   <= 1'b0;
    end else if (take) begin
      cur_addr <= addr;
      cur_rd   <= rd;
    end
  end
endmodule

// File: rtl/i2c_msg_seq.sv
module i2c_msg_seq
  import i2c_seq_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int LEN_W  = 8,
  parameter int CNT_W  = 8,
  parameter int TMO_W  = 16,
  localparam int CMD_W = ADDR_W + 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              desc_valid,
  output logic              desc_ready,
  input  logic [ADDR_W-1:0] desc_addr,
  input  logic              desc_rd,
  input  logic [LEN_W-1:0]  desc_len,
  input  logic              desc_last,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [7:0]        wr_data,
  output logic              cmd_valid,
  output logic [CMD_W-1:0]  cmd_word,
  input  logic              cmd_full,
  input  logic              tx_empty,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_pop,
  input  logic              abort,
  input  logic [2:0]        abort_src,
  input  logic [TMO_W-1:0]  tmo_limit,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              done,
  output logic [CNT_W-1:0]  done_count,
  output logic [STAT_W-1:0] done_status
);
  localparam logic [LEN_W-1:0] ONE_LEFT = LEN_W'(1);

  seq_state_e        st;
  logic [ADDR_W-1:0] m_addr;
  logic              m_last, m_rs, list_start;
  logic [LEN_W-1:0]  remain;
  logic [CNT_W-1:0]  ok_cnt;
  logic [STAT_W-1:0] err_code;

  logic take, wr_fire, rd_iss, tx_done, last_unit, new_rs;
  logic t_run, t_prog, tmo_exp;
  logic fail, msg_ok;
  logic [STAT_W-1:0] fail_code;

  assign desc_ready = (st == S_GET) || (st == S_DRAIN);
  assign take       = desc_valid && desc_ready;
  assign wr_ready   = (st == S_WR) && !cmd_full;
  assign wr_fire    = wr_valid && wr_ready;
  assign rd_iss     = (st == S_RD_ISS) && !cmd_full;
  assign rx_pop     = (st == S_RD_WAIT) && !abort && rx_valid;
  assign tx_done    = (st == S_WR_WAIT) && !abort && tx_empty && !cmd_valid;
  assign last_unit  = (remain == ONE_LEFT);

  assign t_run  = (st == S_WR) || (st == S_WR_WAIT) || (st == S_RD_ISS) || (st == S_RD_WAIT);
  assign t_prog = wr_fire || rd_iss || rx_pop || tx_done;

  seq_stall_timer #(.TMO_W(TMO_W)) u_timer (
    .clk(clk), .rst(rst), .run(t_run), .progress(t_prog),
    .limit(tmo_limit), .expired(tmo_exp)
  );

  seq_pair_track #(.ADDR_W(ADDR_W)) u_pair (
    .clk(clk), .rst(rst), .take(take && (st == S_GET)),
    .list_start(list_start), .addr(desc_addr), .rd(desc_rd),
    .restart(new_rs)
  );

  // outcome of the current message for this cycle
  always_comb begin
    fail      = 1'b0;
    fail_code = ST_OK;
    msg_ok    = 1'b0;
    unique case (st)
      S_WR, S_RD_ISS: if (tmo_exp) begin fail = 1'b1; fail_code = ST_WAIT_TMO; end
      S_WR_WAIT, S_RD_WAIT: begin
        if (abort) begin
          fail      = 1'b1;
          fail_code = abort_code(abort_src);
        end else if (tx_done || (rx_pop && last_unit)) begin
          msg_ok = 1'b1;
        end else if (tmo_exp) begin
          fail      = 1'b1;
          fail_code = ST_WAIT_TMO;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_GET;
      m_addr      <= '0;
      m_last      <= 1'b0;
      m_rs        <= 1'b0;
      list_start  <= 1'b1;
      remain      <= '0;
      ok_cnt      <= '0;
      err_code    <= ST_OK;
      cmd_valid   <= 1'b0;
      cmd_word    <= '0;
      rd_valid    <= 1'b0;
      rd_data     <= '0;
      done        <= 1'b0;
      done_count  <= '0;
      done_status <= ST_OK;
    end else begin
      cmd_valid <= 1'b0;
      rd_valid  <= 1'b0;
      done      <= 1'b0;
      unique case (st)
        S_GET: if (take) begin
          m_addr     <= desc_addr;
          m_last     <= desc_last;
          m_rs       <= new_rs;
          remain     <= desc_len;
          list_start <= 1'b0;
          if (desc_len == '0) begin
            err_code <= ST_ABORT;
            st       <= desc_last ? S_DONE : S_DRAIN;
          end else begin
            st <= desc_rd ? S_RD_ISS : S_WR;
          end
        end
        S_WR: if (wr_fire) begin
          cmd_valid <= 1'b1;
          cmd_word  <= {m_addr, m_rs, m_last && last_unit, 1'b0, wr_data};
          m_rs      <= 1'b0;
          remain    <= remain - 1'b1;
          if (last_unit) st <= S_WR_WAIT;
        end
        S_RD_ISS: if (rd_iss) begin
          cmd_valid <= 1'b1;
          cmd_word  <= {m_addr, m_rs, m_last && last_unit, 1'b1, 8'h00};
          m_rs      <= 1'b0;
          st        <= S_RD_WAIT;
        end
        S_RD_WAIT: if (rx_pop) begin
          rd_valid <= 1'b1;
          rd_data  <= rx_data;
          remain   <= remain - 1'b1;
          if (!last_unit) st <= S_RD_ISS;
        end
        S_DRAIN: if (take && desc_last) st <= S_DONE;
        S_DONE: begin
          done        <= 1'b1;
          done_count  <= ok_cnt;
          done_status <= err_code;
          ok_cnt      <= '0;
          err_code    <= ST_OK;
          list_start  <= 1'b1;
          st          <= S_GET;
        end
        default: ;
      endcase
      if (fail) begin
        err_code <= fail_code;
        st       <= m_last ? S_DONE : S_DRAIN;
      end else if (msg_ok) begin
        ok_cnt <= ok_cnt + 1'b1;
        st     <= m_last ? S_DONE : S_GET;
      end
    end
  end
endmodule

// File: rtl/i2c_msg_seq_chk.sv
module i2c_msg_seq_chk #(
  parameter int LEN_W = 8,
  parameter int CMD_W = 18
) (
  input logic             clk,
  input logic             rst,
  input logic             desc_valid,
  input logic             desc_ready,
  input logic [LEN_W-1:0] desc_len,
  input logic             cmd_valid,
  input logic [CMD_W-1:0] cmd_word,
  input logic             cmd_full,
  input logic             rx_valid,
  input logic             rx_pop,
  input logic             done,
  input logic [4:0]       done_status
);
  logic stop_seen;

  always_ff @(posedge clk) begin
    if (rst || done)                  stop_seen <= 1'b0;
    else if (cmd_valid && cmd_word[9]) stop_seen <= 1'b1;
  end

  AST_CMD_AFTER_SPACE: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> !$past(cmd_full)); // R1
  AST_NO_CMD_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
    stop_seen |-> !cmd_valid); // R3
  AST_ZERO_LEN_SILENT: assert property (@(posedge clk) disable iff (rst)
    (desc_valid && desc_ready && desc_len == '0) |=> !cmd_valid ##1 !cmd_valid); // R4
  AST_POP_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
    rx_pop |-> rx_valid); // R5
  AST_ONE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    done |-> $onehot0(done_status)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
endmodule

bind i2c_msg_seq i2c_msg_seq_chk #(.LEN_W(LEN_W), .CMD_W(CMD_W)) u_chk (
  .clk(clk), .rst(rst), .desc_valid(desc_valid), .desc_ready(desc_ready),
  .desc_len(desc_len), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
  .cmd_full(cmd_full), .rx_valid(rx_valid), .rx_pop(rx_pop),
  .done(done), .done_status(done_status)
);

// File: tb/i2c_msg_seq_tb_top.sv
`timescale 1ns/1ps
module i2c_msg_seq_tb_top;
  localparam int AW = 7, LW = 4, CW = 4, TW = 8, CMDW = AW + 11;

  logic clk = 1'b0, rst = 1'b1;
  logic desc_valid = 1'b0, desc_ready, desc_rd = 1'b0, desc_last = 1'b0;
  logic [AW-1:0] desc_addr = '0;
  logic [LW-1:0] desc_len = '0;
  logic wr_valid = 1'b0, wr_ready;
  logic [7:0] wr_data = '0;
  logic cmd_valid, cmd_full = 1'b0, tx_empty = 1'b1;
  logic [CMDW-1:0] cmd_word;
  logic rx_valid = 1'b0, rx_pop;
  logic [7:0] rx_data = '0;
  logic abort = 1'b0;
  logic [2:0] abort_src = '0;
  logic [TW-1:0] tmo_limit = 8'd20;
  logic rd_valid, done;
  logic [7:0] rd_data;
  logic [CW-1:0] done_count;
  logic [4:0] done_status;

  always #2.5 clk = ~clk;

  i2c_msg_seq #(.ADDR_W(AW), .LEN_W(LW), .CNT_W(CW), .TMO_W(TW)) dut_i (.*);

  typedef struct packed {
    logic [AW-1:0] a; logic rd; logic [LW-1:0] len; logic last;
  } desc_t;

  desc_t            dq[$];
  logic [7:0]       wq[$];
  logic [CMDW-1:0]  exp_cmd_q[$];
  string            exp_cmd_tag[$];
  logic [7:0]       exp_rd_q[$];
  logic [CW+4:0]    exp_done_q[$];
  string            exp_done_tag[$];
  int n_chk = 0, n_fail = 0, done_seen = 0, exp_rx = 0, rx_cnt = 0;
  bit rx_en = 1'b1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // stream feeders: handshake sampled at the edge, next item driven by NBA
  always @(posedge clk) begin
    if (desc_valid && desc_ready) void'(dq.pop_front());
    if (dq.size() > 0) begin
      desc_valid <= 1'b1;
      {desc_addr, desc_rd, desc_len, desc_last} <= dq[0];
    end else desc_valid <= 1'b0;
    if (wr_valid && wr_ready) void'(wq.pop_front());
    if (wq.size() > 0) begin
      wr_valid <= 1'b1;
      wr_data  <= wq[0];
    end else wr_valid <= 1'b0;
  end

  // receiver model: one byte answers each read command
  always @(posedge clk) begin
    if (rx_valid && rx_pop) rx_valid <= 1'b0;
    if (cmd_valid && cmd_word[8] && rx_en) begin
      rx_valid <= 1'b1;
      rx_data  <= 8'h40 + 8'(rx_cnt);
      rx_cnt++;
    end
    if (done) rx_valid <= 1'b0;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (cmd_valid) begin
        if (exp_cmd_q.size() == 0) chk("R1 unexpected command", 32'(cmd_word), 32'hFFFFFFFF);
        else chk(exp_cmd_tag.pop_front(), 32'(cmd_word), 32'(exp_cmd_q.pop_front()));
      end
      if (rd_valid) begin
        if (exp_rd_q.size() == 0) chk("R5 unexpected read byte", 32'(rd_data), 32'hFFFFFFFF);
        else chk("R5 read byte", 32'(rd_data), 32'(exp_rd_q.pop_front()));
      end
      if (done) begin
        done_seen++;
        if (exp_done_q.size() == 0) chk("R9 unexpected done", 32'({done_count, done_status}), 32'hFFFFFFFF);
        else chk(exp_done_tag.pop_front(), 32'({done_count, done_status}), 32'(exp_done_q.pop_front()));
      end
    end
  end

  task automatic desc(input logic [AW-1:0] a, input logic rd, input logic [LW-1:0] len, input logic last);
    dq.push_back({a, rd, len, last});
  endtask
  task automatic wb(input logic [7:0] d); wq.push_back(d); endtask
  task automatic e_cmd(input logic [AW-1:0] a, input logic rs, input logic sp,
                       input logic [7:0] d, input string tag);
    exp_cmd_q.push_back({a, rs, sp, 1'b0, d});
    exp_cmd_tag.push_back(tag);
  endtask
  task automatic e_rdcmd(input logic [AW-1:0] a, input logic rs, input logic sp,
                         input bit data, input string tag);
    exp_cmd_q.push_back({a, rs, sp, 1'b1, 8'h00});
    exp_cmd_tag.push_back(tag);
    if (data) begin
      exp_rd_q.push_back(8'h40 + 8'(exp_rx));
      exp_rx++;
    end
  endtask
  task automatic e_done(input logic [CW-1:0] c, input logic [4:0] s, input string tag);
    exp_done_q.push_back({c, s});
    exp_done_tag.push_back(tag);
  endtask

  task automatic wait_done(input string tag);
    int s = done_seen;
    while (done_seen == s) @(posedge clk);
    repeat (3) @(negedge clk);
    chk({tag, " commands left"}, 32'(exp_cmd_q.size()), 0);
    chk({tag, " read bytes left"}, 32'(exp_rd_q.size()), 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_chk + 1, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 desc_ready", 32'(desc_ready), 1);
    chk("R10 cmd_valid", 32'(cmd_valid), 0);
    chk("R10 rd_valid", 32'(rd_valid), 0);
    chk("R10 done", 32'(done), 0);

    // write then read to the same target: direction change restarts
    e_cmd(7'h50, 0, 0, 8'h11, "R1 write byte 0");
    e_cmd(7'h50, 0, 0, 8'h22, "R3 no stop inside list");
    e_rdcmd(7'h50, 1, 0, 1, "R2 restart on direction change");
    e_rdcmd(7'h50, 0, 1, 1, "R3 stop on final read");
    e_done(2, 5'h00, "R9 clean list");
    wb(8'h11); wb(8'h22);
    desc(7'h50, 0, 2, 0); desc(7'h50, 1, 2, 1);
    wait_done("R5");

    // address change restarts, same pair does not
    e_cmd(7'h50, 0, 0, 8'hA1, "R2 list start never restarts");
    e_cmd(7'h51, 1, 0, 8'hB1, "R2 restart on address change");
    e_cmd(7'h51, 0, 0, 8'hC1, "R2 same pair no restart");
    e_cmd(7'h51, 0, 1, 8'hC2, "R3 stop on final write");
    e_done(3, 5'h00, "R9 three messages");
    wb(8'hA1); wb(8'hB1); wb(8'hC1); wb(8'hC2);
    desc(7'h50, 0, 1, 0); desc(7'h51, 0, 1, 0); desc(7'h51, 0, 2, 1);
    wait_done("R2");

    // zero-length as only message, then as first of two
    e_done(0, 5'h10, "R4 zero length rejected");
    desc(7'h22, 0, 0, 1);
    wait_done("R4");
    e_done(0, 5'h10, "R6 zero length drains rest");
    desc(7'h22, 1, 0, 0); desc(7'h22, 0, 1, 1);
    wait_done("R6");

    // data NACK on first write, later messages dropped
    abort = 1'b1; abort_src = 3'b010;
    e_cmd(7'h30, 0, 0, 8'h5A, "R1 byte before nack");
    e_done(0, 5'h02, "R7 data nack");
    wb(8'h5A);
    desc(7'h30, 0, 1, 0); desc(7'h30, 1, 1, 0); desc(7'h30, 1, 3, 1);
    wait_done("R6");

    // address NACK while a read waits
    abort_src = 3'b001; rx_en = 1'b0;
    e_rdcmd(7'h31, 0, 0, 0, "R5 single read command");
    e_done(0, 5'h01, "R7 address nack");
    desc(7'h31, 1, 2, 1);
    wait_done("R7");
    rx_en = 1'b1;

    // hardware timeout cause, then abort with no cause bits
    abort_src = 3'b100;
    e_cmd(7'h32, 0, 1, 8'h77, "R3 stop on single byte");
    e_done(0, 5'h04, "R7 hardware timeout");
    wb(8'h77); desc(7'h32, 0, 1, 1);
    wait_done("R7");
    abort_src = 3'b000;
    e_cmd(7'h33, 0, 1, 8'h78, "R1 byte before generic abort");
    e_done(0, 5'h10, "R7 generic abort");
    wb(8'h78); desc(7'h33, 0, 1, 1);
    wait_done("R7");
    abort = 1'b0;

    // write data withheld: wait timeout
    e_cmd(7'h34, 0, 0, 8'h01, "R1 first byte before stall");
    e_done(0, 5'h08, "R8 wait timeout on write data");
    wb(8'h01); desc(7'h34, 0, 2, 1);
    wait_done("R8");

    // queue full for fewer cycles than the limit: no timeout
    cmd_full = 1'b1;
    e_cmd(7'h35, 0, 0, 8'h09, "R1 held while full");
    e_cmd(7'h35, 0, 1, 8'h08, "R3 stop after stall");
    e_done(1, 5'h00, "R8 stall under limit");
    wb(8'h09); wb(8'h08); desc(7'h35, 0, 2, 1);
    repeat (15) @(negedge clk);
    chk("R1 no command while full", 32'(exp_cmd_q.size()), 2);
    cmd_full = 1'b0;
    wait_done("R8");

    // silent receiver after a good write: count of completed messages kept
    rx_en = 1'b0;
    e_cmd(7'h37, 0, 0, 8'h3C, "R1 write before read");
    e_rdcmd(7'h38, 1, 1, 0, "R2 restart on both changes");
    e_done(1, 5'h08, "R6 count before failure");
    wb(8'h3C); desc(7'h37, 0, 1, 0); desc(7'h38, 1, 1, 1);
    wait_done("R8");
    rx_en = 1'b1;

    chk("R9 all done pulses seen", 32'(exp_done_q.size()), 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule